// File: doc/BRIEF.md
# Identification Page Write and Lock Controller

This block is the transaction layer behind the extra 64-byte identification page of a serial EEPROM. A bus front end that has already decoded the serial framing hands it events: a device-select event with a 4-bit type code and a read/write flag, a stop event, a stream of received bytes, and read requests. The block works out what each byte means. The first two bytes after a write select are the address, and the rest are data or a lock payload. It steers page writes into a 64-byte register array, carries out the one-way lock, and returns an acknowledge decision for every byte it owns.

Type code 1011b addresses the page. Bit 2 of the high address byte chooses between a page write (0) and a lock request (1). Written bytes are collected in a staging buffer and reach the page only when a stop arrives. A new device select discards whatever is staged. Once the lock flag is set, it stays set until the asynchronous reset, which stands for a return to factory state. From then on, data bytes of page writes are refused and nothing is stored. Reads return committed page bytes from an auto-incrementing in-page pointer.

The state machine has eight states:

| State | Meaning |
|---|---|
| IDLE | No transaction |
| SKIP | Another device is addressed; bytes are ignored |
| AHI | Expecting the high address byte |
| ALO | Expecting the low address byte |
| WDAT | Page-write data |
| LDAT | Expecting the lock payload |
| LDONE | Lock payload received |
| READ | Serving reads |

The transitions are:

- Any state goes to AHI on a write select with type 1011b.
- Any state goes to READ on a read select with type 1011b.
- Any state goes to SKIP on a select with any other type.
- Any state goes to IDLE on stop.
- AHI goes to ALO on a byte.
- ALO goes to WDAT on a byte when A10 is 0, or to LDAT when A10 is 1.
- LDAT goes to LDONE on a byte.

Top module: `idp_lock_ctrl`

## Requirements
- R1: While reset is asserted, `locked`, `ack_vld`, `ack_ok` and `rd_data` are 0, and every page byte reads back as 8'hFF afterwards.
- R2: After a select whose type code differs from 4'b1011, bytes produce no acknowledge (`ack_vld` stays 0) and change neither the page nor the lock.
- R3: With type 4'b1011 and write flag 0, the two following bytes are high then low address bytes. Each one gives `ack_vld`=1 and `ack_ok`=1 in the cycle after the byte. Bit 2 of the high byte is the command select; its other bits are ignored.
- R4: For a write (select bit 0), bits 5:0 of the low byte set the start position. Each data byte fills the next position, and position 63 wraps to 0.
- R5: Staged bytes are committed to the page only on `ev_stop`. A new select before stop discards them and leaves the page unchanged.
- R6: A data byte that arrives in the same cycle as `ev_stop` is acknowledged and included in that commit.
- R7: For a lock request (select bit 1), a payload byte with bit 1 equal to 1, followed by stop, sets `locked` in the cycle after the stop. The payload may also arrive in the stop cycle. The payload byte and any further bytes are acknowledged.
- R8: A lock payload with bit 1 equal to 0, or a lock request ended by a new select instead of stop, leaves `locked` unchanged.
- R9: While `locked` is 1, page-write data bytes give `ack_vld`=1 with `ack_ok`=0 and are not stored. Address bytes are still acknowledged. No other byte is ever refused.
- R10: With type 4'b1011 and read flag 1, each `rd_req` returns the committed byte at the pointer on `rd_data` in the next cycle, then advances the pointer with wrap at 63. The pointer keeps the position set by a preceding address write. `rd_data` changes only after an `rd_req`.
- R11: Once set, `locked` stays 1 until `rst_n` is asserted, and that reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the factory clear of the lock |
| ev_dev | input | 1 | Device-select event (start plus type byte) |
| dev_code | input | 4 | Device type code carried with `ev_dev` |
| dev_rnw | input | 1 | Read (1) or write (0) flag carried with `ev_dev` |
| byte_vld | input | 1 | A received byte is present |
| byte_dat | input | 8 | Received byte |
| ev_stop | input | 1 | Stop event |
| rd_req | input | 1 | Request for the next read byte |
| ack_vld | output | 1 | An acknowledge decision is presented for the previous byte |
| ack_ok | output | 1 | 1 to acknowledge, 0 to refuse |
| rd_data | output | 8 | Read byte, valid the cycle after `rd_req` |
| locked | output | 1 | Identification page is permanently read-only |

## Verification
Two functions can fall in the same cycle, and the bench provokes both. A last write byte can arrive together with stop, so the byte must be staged and committed at once. A lock payload can arrive together with stop, so the flag must be set from a payload that was never registered. The bench sends those byte-plus-stop cycles and judges them two ways. It compares the acknowledge and lock outputs on every clock with a behavioural model, and it reads the page back through read transactions to confirm that the merged byte landed at its position.

// File: rtl/idp_pkg.sv
package idp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SKIP,
        S_AHI,
        S_ALO,
        S_WDAT,
        S_LDAT,
        S_LDONE,
        S_READ
    } idp_state_e;
endpackage

// File: rtl/idp_seq.sv
module idp_seq
    import idp_pkg::*;
#(
    parameter int          AW       = 6,
    parameter logic [3:0]  DEV_ID   = 4'b1011,
    parameter int          SEL_BIT  = 2,
    parameter int          LOCK_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_dev,
    input  logic [3:0]        dev_code,
    input  logic              dev_rnw,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              ev_stop,
    input  logic              rd_req,
    input  logic              locked,
    output logic              stage_we,
    output logic [AW-1:0]     stage_addr,
    output logic [BYTE_W-1:0] stage_dat,
    output logic              stage_clr,
    output logic              commit,
    output logic              lock_set,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              ack_vld,
    output logic              ack_ok
);
    localparam logic [AW-1:0] PTR_ONE = {{(AW-1){1'b0}}, 1'b1};

    idp_state_e  state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic        a10_q, a10_d;
    logic        arm_q, arm_d;
    logic        byte_take;
    logic        owns_byte;
    logic        refuse;

    assign byte_take = byte_vld && !ev_dev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            a10_q   <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            a10_q   <= a10_d;
            arm_q   <= arm_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        a10_d   = a10_q;
        arm_d   = arm_q;
        if (byte_take) begin
            unique case (state_q)
                S_AHI: begin
                    a10_d   = byte_dat[SEL_BIT];
                    state_d = S_ALO;
                end
                S_ALO: begin
                    ptr_d   = byte_dat[AW-1:0];
                    state_d = a10_q ? S_LDAT : S_WDAT;
                end
                S_WDAT: begin
                    if (!locked) ptr_d = ptr_q + PTR_ONE;
                end
                S_LDAT: begin
                    arm_d   = byte_dat[LOCK_BIT];
                    state_d = S_LDONE;
                end
                S_IDLE, S_SKIP, S_LDONE, S_READ: ;
                default: ;
            endcase
        end
        if (rd_req && state_q == S_READ) ptr_d = ptr_q + PTR_ONE;
        if (ev_stop) begin
            state_d = S_IDLE;
            arm_d   = 1'b0;
        end else if (ev_dev) begin
            arm_d = 1'b0;
            if (dev_code != DEV_ID) state_d = S_SKIP;
            else                    state_d = dev_rnw ? S_READ : S_AHI;
        end
    end

    // outputs
    always_comb begin
        owns_byte = 1'b0;
        refuse    = 1'b0;
        unique case (state_q)
            S_AHI, S_ALO, S_LDAT, S_LDONE: owns_byte = 1'b1;
            S_WDAT: begin
                owns_byte = 1'b1;
                refuse    = locked;
            end
            S_IDLE, S_SKIP, S_READ: owns_byte = 1'b0;
            default: owns_byte = 1'b0;
        endcase
        stage_we   = byte_take && state_q == S_WDAT && !locked;
        stage_addr = ptr_q;
        stage_dat  = byte_dat;
        stage_clr  = ev_stop || ev_dev;
        commit     = ev_stop && state_q == S_WDAT;
        lock_set   = ev_stop && ((state_q == S_LDAT && byte_take && byte_dat[LOCK_BIT])
                               || (state_q == S_LDONE && arm_q));
        rd_en      = rd_req && state_q == S_READ;
        rd_addr    = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vld <= 1'b0;
            ack_ok  <= 1'b0;
        end else begin
            ack_vld <= byte_take && owns_byte;
            ack_ok  <= byte_take && owns_byte && !refuse;
        end
    end
endmodule

// File: rtl/idp_store.sv
module idp_store
    import idp_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    localparam int AW = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_we,
    input  logic [AW-1:0]     stage_addr,
    input  logic [BYTE_W-1:0] stage_dat,
    input  logic              stage_clr,
    input  logic              commit,
    input  logic              lock_set,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              locked
);
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_q;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] stg_q;
    logic [PAGE_BYTES-1:0]             msk_q;
    logic [PAGE_BYTES-1:0]             hit;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
        assign hit[g] = stage_we && (stage_addr == AW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '1;
            stg_q  <= '0;
            msk_q  <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (hit[i]) stg_q[i] <= stage_dat;
                if (commit && hit[i])          page_q[i] <= stage_dat;
                else if (commit && msk_q[i])   page_q[i] <= stg_q[i];
                if (stage_clr)   msk_q[i] <= 1'b0;
                else if (hit[i]) msk_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            rd_data <= '0;
        end else begin
            if (lock_set) locked <= 1'b1;
            if (rd_en)    rd_data <= page_q[rd_addr];
        end
    end
endmodule

// File: rtl/idp_lock_ctrl.sv
module idp_lock_ctrl
    import idp_pkg::*;
#(
    parameter int          PAGE_BYTES = 64,
    parameter logic [3:0]  DEV_ID     = 4'b1011,
    parameter int          SEL_BIT    = 2,
    parameter int          LOCK_BIT   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_dev,
    input  logic [3:0] dev_code,
    input  logic       dev_rnw,
    input  logic       byte_vld,
    input  logic [7:0] byte_dat,
    input  logic       ev_stop,
    input  logic       rd_req,
    output logic       ack_vld,
    output logic       ack_ok,
    output logic [7:0] rd_data,
    output logic       locked
);
    localparam int AW = $clog2(PAGE_BYTES);

    logic              stage_we, stage_clr, commit, lock_set, rd_en;
    logic [AW-1:0]     stage_addr, rd_addr;
    logic [BYTE_W-1:0] stage_dat;

    idp_seq #(
        .AW(AW), .DEV_ID(DEV_ID), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .ev_dev(ev_dev), .dev_code(dev_code),
        .dev_rnw(dev_rnw), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .ev_stop(ev_stop), .rd_req(rd_req), .locked(locked),
        .stage_we(stage_we), .stage_addr(stage_addr), .stage_dat(stage_dat),
        .stage_clr(stage_clr), .commit(commit), .lock_set(lock_set),
        .rd_en(rd_en), .rd_addr(rd_addr), .ack_vld(ack_vld), .ack_ok(ack_ok)
    );

    idp_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_addr(stage_addr),
        .stage_dat(stage_dat), .stage_clr(stage_clr), .commit(commit),
        .lock_set(lock_set), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .locked(locked)
    );
endmodule

// File: rtl/idp_lock_chk.sv
module idp_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       ev_stop,
    input logic       rd_req,
    input logic       ack_vld,
    input logic       ack_ok,
    input logic [7:0] rd_data,
    input logic       locked
);
    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R7
    lock_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ev_stop));

    // R9
    refuse_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !ack_ok) |-> locked);

    // R3
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req) |-> $stable(rd_data));
endmodule

bind idp_lock_ctrl idp_lock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .ev_stop(ev_stop),
    .rd_req(rd_req), .ack_vld(ack_vld), .ack_ok(ack_ok),
    .rd_data(rd_data), .locked(locked)
);

// File: tb/sim_idp_lock_ctrl.sv
module sim_idp_lock_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [3:0] ID = 4'b1011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_dev = 0, dev_rnw = 0, byte_vld = 0, ev_stop = 0, rd_req = 0;
    logic [3:0] dev_code = 0;
    logic [7:0] byte_dat = 0;
    logic       ack_vld, ack_ok, locked;
    logic [7:0] rd_data;

    int compared = 0;
    int mismatched = 0;
    string phase = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idp_lock_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ev_dev(ev_dev), .dev_code(dev_code),
        .dev_rnw(dev_rnw), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .ev_stop(ev_stop), .rd_req(rd_req), .ack_vld(ack_vld),
        .ack_ok(ack_ok), .rd_data(rd_data), .locked(locked)
    );

    // behavioural reference
    localparam int M_IDLE = 0, M_SKIP = 1, M_AHI = 2, M_ALO = 3,
                   M_WDAT = 4, M_LDAT = 5, M_LDONE = 6, M_READ = 7;
    int   m_st, m_ptr;
    bit   m_a10, m_arm, m_lock;
    byte  m_page [64];
    byte  m_stg  [64];
    bit   m_msk  [64];
    bit   e_ackv, e_acko;
    byte  e_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; m_ptr = 0; m_a10 = 0; m_arm = 0; m_lock = 0;
            foreach (m_page[i]) begin m_page[i] = 8'hFF; m_msk[i] = 0; end
            e_ackv = 0; e_acko = 0; e_rd = 0;
        end else begin
            e_ackv = 0; e_acko = 0;
            if (byte_vld && !ev_dev) begin
                if (m_st == M_AHI) begin
                    e_ackv = 1; e_acko = 1; m_a10 = byte_dat[2]; m_st = M_ALO;
                end else if (m_st == M_ALO) begin
                    e_ackv = 1; e_acko = 1; m_ptr = byte_dat % 64;
                    m_st = m_a10 ? M_LDAT : M_WDAT;
                end else if (m_st == M_WDAT) begin
                    e_ackv = 1;
                    if (!m_lock) begin
                        e_acko = 1; m_stg[m_ptr] = byte_dat; m_msk[m_ptr] = 1;
                        m_ptr = (m_ptr + 1) % 64;
                    end
                end else if (m_st == M_LDAT) begin
                    e_ackv = 1; e_acko = 1; m_arm = byte_dat[1]; m_st = M_LDONE;
                end else if (m_st == M_LDONE) begin
                    e_ackv = 1; e_acko = 1;
                end
            end
            if (rd_req && m_st == M_READ) begin
                e_rd = m_page[m_ptr]; m_ptr = (m_ptr + 1) % 64;
            end
            if (ev_stop) begin
                if (m_st == M_WDAT)
                    foreach (m_msk[i]) if (m_msk[i]) m_page[i] = m_stg[i];
                if (m_st == M_LDONE && m_arm) m_lock = 1;
                foreach (m_msk[i]) m_msk[i] = 0;
                m_arm = 0; m_st = M_IDLE;
            end else if (ev_dev) begin
                foreach (m_msk[i]) m_msk[i] = 0;
                m_arm = 0;
                m_st = (dev_code != ID) ? M_SKIP : (dev_rnw ? M_READ : M_AHI);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (ack_vld !== e_ackv || ack_ok !== e_acko || locked !== e_lock_v() || rd_data !== e_rd) begin
                mismatched++;
                $display("FAIL %s model: ack_vld=%b/%b ack_ok=%b/%b locked=%b/%b rd=%h/%h (actual/expected)",
                         phase, ack_vld, e_ackv, ack_ok, e_acko, locked, m_lock, rd_data, e_rd);
            end
        end
    end

    function automatic bit e_lock_v();
        return m_lock;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sel(logic [3:0] code, logic rnw);
        @(negedge clk); ev_dev = 1; dev_code = code; dev_rnw = rnw;
        @(negedge clk); ev_dev = 0;
    endtask

    task automatic put(logic [7:0] b, logic with_stop = 0);
        @(negedge clk); byte_vld = 1; byte_dat = b; ev_stop = with_stop;
        @(negedge clk); byte_vld = 0; ev_stop = 0;
    endtask

    task automatic stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
    endtask

    task automatic rd();
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
    endtask

    task automatic seek(logic [7:0] pos);
        sel(ID, 0); put(8'h00); put(pos); sel(ID, 1);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1 locked", {7'd0, locked}, 8'h00);
        check("R1 ack", {6'd0, ack_vld, ack_ok}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        rst_n = 1;

        phase = "R2";
        sel(4'b1010, 0); put(8'h00); check("R2 no ack", {7'd0, ack_vld}, 8'h00);
        put(8'h00); put(8'h5A); stop();
        seek(8'h00); rd(); check("R2 page", rd_data, 8'hFF);
        check("R1 erased", rd_data, 8'hFF); stop();

        phase = "R3";
        sel(ID, 0); put(8'hF8); check("R3 hi ack", {6'd0, ack_vld, ack_ok}, 8'h03);
        put(8'hC5); check("R3 lo ack", {6'd0, ack_vld, ack_ok}, 8'h03);
        phase = "R4";
        put(8'h11); put(8'h22); put(8'h33); put(8'h44); stop();
        seek(8'h05);
        rd(); check("R4 pos5", rd_data, 8'h11);
        rd(); check("R4 pos6", rd_data, 8'h22);
        rd(); check("R4 pos7", rd_data, 8'h33);
        rd(); check("R4 pos8", rd_data, 8'h44);
        rd(); check("R4 pos9", rd_data, 8'hFF); stop();

        sel(ID, 0); put(8'h00); put(8'h3E); put(8'hA1); put(8'hA2); put(8'hA3); stop();
        phase = "R10";
        seek(8'h3E);
        rd(); check("R4 pos62", rd_data, 8'hA1);
        rd(); check("R4 pos63", rd_data, 8'hA2);
        rd(); check("R10 wrap pos0", rd_data, 8'hA3);
        rd(); check("R10 pos1", rd_data, 8'hFF); stop();

        phase = "R5";
        sel(ID, 0); put(8'h00); put(8'h10); put(8'h55);
        check("R5 staged byte ack", {7'd0, ack_ok}, 8'h01);
        sel(ID, 1); rd(); stop();
        seek(8'h10); rd(); check("R5 aborted write", rd_data, 8'hFF); stop();

        phase = "R6";
        sel(ID, 0); put(8'h00); put(8'h20); put(8'h66); put(8'h77, 1);
        check("R6 ack with stop", {6'd0, ack_vld, ack_ok}, 8'h03);
        seek(8'h20);
        rd(); check("R6 pos32", rd_data, 8'h66);
        rd(); check("R6 merged byte", rd_data, 8'h77); stop();

        phase = "R8";
        sel(ID, 0); put(8'h04); put(8'h00); put(8'hFD);
        check("R8 payload ack", {6'd0, ack_vld, ack_ok}, 8'h03);
        stop(); check("R8 bit1 clear", {7'd0, locked}, 8'h00);
        sel(ID, 0); put(8'hFF); put(8'h3F); put(8'h02); sel(4'b1010, 0); stop();
        check("R8 aborted lock", {7'd0, locked}, 8'h00);

        phase = "R7";
        sel(ID, 0); put(8'h04); put(8'h00); put(8'h02); put(8'h00);
        check("R7 extra byte ack", {6'd0, ack_vld, ack_ok}, 8'h03);
        check("R7 not yet", {7'd0, locked}, 8'h00);
        stop(); check("R7 locked", {7'd0, locked}, 8'h01);

        phase = "R9";
        sel(ID, 0); put(8'h00); check("R9 addr ack", {6'd0, ack_vld, ack_ok}, 8'h03);
        put(8'h05); put(8'h99);
        check("R9 refused", {6'd0, ack_vld, ack_ok}, 8'h02);
        put(8'h98, 1);
        seek(8'h05); rd(); check("R9 not stored", rd_data, 8'h11); stop();

        phase = "R11";
        repeat (5) @(negedge clk);
        check("R11 sticky", {7'd0, locked}, 8'h01);
        rst_n = 0; @(negedge clk);
        check("R11 cleared", {7'd0, locked}, 8'h00);
        rst_n = 1;
        seek(8'h05); rd(); check("R11 page erased", rd_data, 8'hFF); stop();
        sel(ID, 0); put(8'h04); put(8'h00); put(8'h06, 1);
        check("R7 payload in stop cycle", {7'd0, locked}, 8'h01);

        repeat (3) @(negedge clk);
        done = 1;
        report();
    end
endmodule